// File: doc/BRIEF.md
# PCM Voice Serial Port with Receive Attenuation Field

This block is the serial side of a single-channel voice interface. On transmit it takes a 13-bit linear sample from the core and sends it one bit per bit-clock period, most significant bit first, after a transmit frame sync. It drives an output enable that marks the active slots, so a pad can tri-state the line outside them. On receive it collects a 16-bit word after a receive frame sync. The leading 13 bits are the sample. The trailing three bits are a control code that sets the attenuation of the analog output path downstream.

The bit clocks, frame syncs and receive data are asynchronous to the block's system clock. They are resynchronised and edge-detected, so the block works entirely on `clk_i`. Frame syncs can be short (one bit period, ahead of the MSB) or long (two or more periods, starting with the MSB). The format is worked out from how wide the sync is. When a shared-clock mode is selected, the receive side runs on the transmit bit clock. Its frame sync keeps its own timing.

Top module: `pcm_gain_port`

## Requirements
- R1: While `tx_en_o` is high, `tx_data_o` carries `tx_sample_i` MSB first. There is one bit per transmit bit period, and each bit changes only after a rising transmit bit-clock edge. `tx_en_o` is high for exactly 13 consecutive bit periods per frame and low otherwise.
- R2: With a short frame sync (high for exactly one bit period), the transmit MSB occupies the bit period that follows the sync period. The receive MSB is the bit captured on the falling edge one period after the sync.
- R3: With a long frame sync (high for two or more bit periods), the receive MSB is the bit captured in the first period of the sync. The transmit MSB occupies the first sync period when the preceding transmit sync was also long.
- R4: The transmit side uses the format measured from the width of the previous transmit frame sync, and short after reset. For example, the first long sync after a short one still yields short-format timing, and the first short sync after a long one yields long-format timing.
- R5: Receive bits are numbered 1 to 16 in arrival order. After bit 16 is captured on a falling edge, `rx_valid_o` pulses for one clock. At that point `rx_sample_o` holds bits 1..13 (bit 1 in the MSB) and `rx_atten_o` holds {bit 14, bit 15, bit 16}.
- R6: `rx_sample_o` and `rx_atten_o` change only together with an `rx_valid_o` pulse. A new receive sync arriving before 16 bits have been captured discards the partial word and starts a new one, without any pulse.
- R7: Receive bits after bit 16 of a frame are ignored, and the outputs keep the completed word.
- R8: With `shared_clk_i` high, the receive side uses the transmit bit clock and ignores `bclk_rx_i`. Its frame sync may occur at a different bit period from the transmit sync.
- R9: With `shared_clk_i` low, the receive side uses `bclk_rx_i` only and works while the transmit bit clock is idle.
- R10: During reset, `tx_en_o`, `tx_data_o`, `rx_valid_o`, `rx_sample_o` and `rx_atten_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shared_clk_i | input | 1 | 1: receive uses the transmit bit clock |
| bclk_tx_i | input | 1 | Transmit bit clock |
| bclk_rx_i | input | 1 | Receive bit clock |
| fs_tx_i | input | 1 | Transmit frame sync |
| fs_rx_i | input | 1 | Receive frame sync |
| rx_data_i | input | 1 | Serial receive data |
| tx_sample_i | input | 13 | Sample to transmit, taken at the MSB slot |
| tx_data_o | output | 1 | Serial transmit data |
| tx_en_o | output | 1 | Transmit output enable |
| rx_sample_o | output | 13 | Last completed received sample |
| rx_atten_o | output | 3 | Last completed attenuation code |
| rx_valid_o | output | 1 | One-clock pulse per completed receive word |

## Verification
Two situations are hard to reach from the ports. The first is the transmit side applying the sync format remembered from the previous frame, which only shows when the format changes between frames. The stimulus therefore alternates short and long syncs and expects the stale timing on the first frame after each switch. The second is an aborted receive word. The bench raises the receive sync a second time a few bits into a word and expects exactly one word, the later one, from the scoreboard queue. Shared-clock operation is exercised with the receive clock tied high and the receive sync offset from the transmit sync.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int PCM_SAMPLE_W = 13;
  localparam int PCM_CTRL_W   = 3;
  localparam int PCM_SYNC_N   = 2;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcm_edge.sv
module pcm_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx #(
  parameter int SAMPLE_W = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                fs_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                data_o,
  output logic                en_o
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic                fs_q, seen_long, fmt_long, arm;
  logic [SAMPLE_W-1:0] shreg;
  logic [CNT_W-1:0]    left;
  logic                sync_start;

  assign sync_start = fs_i & ~fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q      <= 1'b0;
      seen_long <= 1'b0;
      fmt_long  <= 1'b0;
      arm       <= 1'b0;
      shreg     <= '0;
      left      <= '0;
      data_o    <= 1'b0;
      en_o      <= 1'b0;
    end else if (rise_i) begin
      fs_q <= fs_i;
      // sync width measured for the next frame's format
      if (sync_start)       seen_long <= 1'b0;
      else if (fs_i && fs_q) seen_long <= 1'b1;
      if (!fs_i && fs_q)    fmt_long  <= seen_long;

      if ((sync_start && fmt_long) || arm) begin
        data_o <= sample_i[SAMPLE_W-1];
        shreg  <= {sample_i[SAMPLE_W-2:0], 1'b0};
        left   <= CNT_W'(SAMPLE_W - 1);
        en_o   <= 1'b1;
        arm    <= 1'b0;
      end else if (sync_start) begin
        arm  <= 1'b1;
        en_o <= 1'b0;
        left <= '0;
      end else if (left != '0) begin
        data_o <= shreg[SAMPLE_W-1];
        shreg  <= {shreg[SAMPLE_W-2:0], 1'b0};
        left   <= left - 1'b1;
      end else begin
        en_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx #(
  parameter int SAMPLE_W = 13,
  parameter int CTRL_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic                fs_i,
  input  logic                data_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                valid_o
);
  localparam int WORD_W = SAMPLE_W + CTRL_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic              fs_q, pend, active;
  logic [WORD_W-1:0] shreg, nxt;
  logic [CNT_W-1:0]  cnt;

  assign nxt = {shreg[WORD_W-2:0], data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q     <= 1'b0;
      pend     <= 1'b0;
      active   <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      sample_o <= '0;
      ctrl_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fall_i) begin
        fs_q <= fs_i;
        if (fs_i && !fs_q) begin
          // tentative MSB: kept if the sync turns out long
          shreg  <= {{(WORD_W-1){1'b0}}, data_i};
          cnt    <= CNT_W'(1);
          active <= 1'b1;
          pend   <= 1'b1;
        end else if (pend && !fs_i) begin
          shreg <= {{(WORD_W-1){1'b0}}, data_i};
          cnt   <= CNT_W'(1);
          pend  <= 1'b0;
        end else if (active) begin
          pend  <= 1'b0;
          shreg <= nxt;
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(WORD_W - 1)) begin
            active   <= 1'b0;
            valid_o  <= 1'b1;
            sample_o <= nxt[WORD_W-1:CTRL_W];
            ctrl_o   <= nxt[CTRL_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_gain_port.sv
module pcm_gain_port
  import pcm_pkg::*;
#(
  parameter int SAMPLE_W = PCM_SAMPLE_W,
  parameter int CTRL_W   = PCM_CTRL_W,
  parameter int SYNC_N   = PCM_SYNC_N
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shared_clk_i,
  input  logic                bclk_tx_i,
  input  logic                bclk_rx_i,
  input  logic                fs_tx_i,
  input  logic                fs_rx_i,
  input  logic                rx_data_i,
  input  logic [SAMPLE_W-1:0] tx_sample_i,
  output logic                tx_data_o,
  output logic                tx_en_o,
  output logic [SAMPLE_W-1:0] rx_sample_o,
  output logic [CTRL_W-1:0]   rx_atten_o,
  output logic                rx_valid_o
);
  localparam int IN_W = 5;

  logic [IN_W-1:0] raw, syn;
  logic tx_rise, tx_fall, rc_rise, rc_fall, rx_fall;

  assign raw = {bclk_tx_i, bclk_rx_i, fs_tx_i, fs_rx_i, rx_data_i};

  pcm_in_sync #(.W(IN_W), .STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  pcm_edge u_edge_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(syn[4]), .rise_o(tx_rise), .fall_o(tx_fall)
  );

  pcm_edge u_edge_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(syn[3]), .rise_o(rc_rise), .fall_o(rc_fall)
  );

  assign rx_fall = shared_clk_i ? tx_fall : rc_fall;

  pcm_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(tx_rise), .fs_i(syn[2]),
    .sample_i(tx_sample_i), .data_o(tx_data_o), .en_o(tx_en_o)
  );

  pcm_rx #(.SAMPLE_W(SAMPLE_W), .CTRL_W(CTRL_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(rx_fall), .fs_i(syn[1]),
    .data_i(syn[0]), .sample_o(rx_sample_o), .ctrl_o(rx_atten_o), .valid_o(rx_valid_o)
  );

  // receive rising edges carry no work; kept for symmetry of the edge units
  logic rc_rise_unused;
  assign rc_rise_unused = rc_rise;
endmodule

// File: rtl/pcm_gain_port_chk.sv
module pcm_gain_port_chk #(
  parameter int SAMPLE_W = 13,
  parameter int CTRL_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tx_rise_i,
  input logic                rx_fall_i,
  input logic                tx_en_i,
  input logic                tx_data_i,
  input logic                rx_valid_i,
  input logic [CTRL_W-1:0]   atten_i,
  input logic [SAMPLE_W-1:0] sample_i
);
  localparam int CW = $clog2(SAMPLE_W + 2) + 1;
  logic [CW-1:0] slot_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_cnt <= '0;
    else if (tx_rise_i) begin
      if (!tx_en_i)            slot_cnt <= '0;
      else if (slot_cnt != '1) slot_cnt <= slot_cnt + 1'b1;
    end
  end

  // R1
  tx_slots_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_cnt <= CW'(SAMPLE_W));

  // R1
  tx_en_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_en_i) |-> $past(tx_rise_i));

  // R1
  tx_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !$past(tx_rise_i)) |-> $stable(tx_data_i));

  // R5
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);

  // R6
  rx_atten_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |-> $stable(atten_i));

  // R6
  rx_sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |-> $stable(sample_i));

  // R8
  rx_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> $past(rx_fall_i));
endmodule

bind pcm_gain_port pcm_gain_port_chk #(.SAMPLE_W(SAMPLE_W), .CTRL_W(CTRL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_rise_i(tx_rise), .rx_fall_i(rx_fall),
  .tx_en_i(tx_en_o), .tx_data_i(tx_data_o), .rx_valid_i(rx_valid_o),
  .atten_i(rx_atten_o), .sample_i(rx_sample_o)
);

// File: tb/pcm_gain_port_tb.sv
module pcm_gain_port_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, shared_clk, bclk_tx, bclk_rx, fs_tx, fs_rx, rx_data;
  logic [12:0] tx_sample;
  logic tx_data_o, tx_en_o, rx_valid_o;
  logic [12:0] rx_sample_o;
  logic [2:0] rx_atten_o;

  pcm_gain_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .shared_clk_i(shared_clk),
    .bclk_tx_i(bclk_tx), .bclk_rx_i(bclk_rx), .fs_tx_i(fs_tx), .fs_rx_i(fs_rx),
    .rx_data_i(rx_data), .tx_sample_i(tx_sample), .tx_data_o(tx_data_o),
    .tx_en_o(tx_en_o), .rx_sample_o(rx_sample_o), .rx_atten_o(rx_atten_o),
    .rx_valid_o(rx_valid_o)
  );

  typedef struct packed { logic [12:0] s; logic [2:0] a; } rx_item_t;
  rx_item_t exp_q[$];
  rx_item_t mon_it, last_it;
  int checks = 0, fails = 0;
  bit tx_clk_on = 1, rx_tied = 0, done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as words complete
  always @(negedge clk) begin
    if (rst_n && rx_valid_o) begin
      if (exp_q.size() == 0) chk(0, "R6", "unexpected rx word", {rx_sample_o, rx_atten_o}, 0);
      else begin
        mon_it = exp_q.pop_front();
        chk(rx_sample_o == mon_it.s, "R5", "rx sample", rx_sample_o, mon_it.s);
        chk(rx_atten_o == mon_it.a, "R5", "rx atten", rx_atten_o, mon_it.a);
      end
    end
  end

  task automatic period(bit fst, bit fsr, bit rxd, bit ck, bit exp_en, bit exp_d, string req);
    @(negedge clk);
    if (tx_clk_on) bclk_tx = 1'b1;
    bclk_rx = 1'b1;
    fs_tx = fst; fs_rx = fsr; rx_data = rxd;
    repeat (7) @(negedge clk);
    if (ck) begin
      chk(tx_en_o == exp_en, req, "tx_en", tx_en_o, exp_en);
      if (exp_en) chk(tx_data_o == exp_d, req, "tx_data", tx_data_o, exp_d);
    end
    @(negedge clk);
    bclk_tx = 1'b0;
    if (!rx_tied) bclk_rx = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic frame(bit tx_long, bit exp_long, bit ck_tx, logic [12:0] txs,
                       bit rx_long, int r_off, logic [15:0] rxw, int abort_at,
                       int n, string req);
    int ts, s;
    tx_sample = txs;
    exp_q.push_back(rx_item_t'(rxw));
    ts = exp_long ? 0 : 1;
    s  = rx_long ? r_off : r_off + 1;
    for (int p = 0; p < n; p++) begin
      bit fst, fsr, rxd, en, d;
      fst = tx_long ? (p < 3) : (p == 0);
      fsr = (rx_long ? (p >= r_off && p < r_off + 3) : (p == r_off)) || (p == abort_at);
      rxd = (p >= s && p < s + 16) ? rxw[15-(p-s)] : 1'($urandom);
      en  = (p >= ts && p < ts + 13);
      d   = en ? txs[12-(p-ts)] : 1'b0;
      period(fst, fsr, rxd, ck_tx, en, d, req);
    end
    // R7: trailing bits left the completed word in place
    last_it = rx_item_t'(rxw);
    chk(rx_atten_o == last_it.a, "R7", "atten after trailing bits", rx_atten_o, last_it.a);
    chk(rx_sample_o == last_it.s, "R7", "sample after trailing bits", rx_sample_o, last_it.s);
    chk(exp_q.size() == 0, "R5", "words outstanding", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; shared_clk = 0; bclk_tx = 0; bclk_rx = 0;
    fs_tx = 0; fs_rx = 0; rx_data = 0; tx_sample = '0;
    repeat (5) @(negedge clk);
    // R10
    chk(tx_en_o == 0, "R10", "tx_en in reset", tx_en_o, 0);
    chk(tx_data_o == 0, "R10", "tx_data in reset", tx_data_o, 0);
    chk(rx_valid_o == 0, "R10", "rx_valid in reset", rx_valid_o, 0);
    chk(rx_sample_o == 0, "R10", "rx_sample in reset", rx_sample_o, 0);
    chk(rx_atten_o == 0, "R10", "rx_atten in reset", rx_atten_o, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 R2: short syncs
    frame(0, 0, 1, 13'h1A5B, 0, 0, 16'hB3C5, -1, 22, "R2");
    frame(0, 0, 1, 13'h0F0F, 0, 3, 16'h5A5A, -1, 24, "R1");
    // R4: first long sync still uses short timing
    frame(1, 0, 1, 13'h1555, 1, 0, 16'hC3A1, -1, 22, "R4");
    // R3: long after long
    frame(1, 1, 1, 13'h0AAA, 1, 2, 16'h7E19, -1, 22, "R3");
    // R4: first short after long uses long timing
    frame(0, 1, 1, 13'h1C01, 0, 1, 16'h9246, -1, 22, "R4");
    frame(0, 0, 1, 13'h0123, 0, 0, 16'hFFFF, -1, 22, "R2");
    // R6: aborted word, only the later word completes
    frame(0, 0, 1, 13'h1F00, 0, 10, 16'h3D8B, 1, 30, "R6");

    // R8: shared clock, receive clock tied high, offset receive sync
    shared_clk = 1; rx_tied = 1; bclk_rx = 1;
    repeat (10) @(negedge clk);
    frame(0, 0, 1, 13'h0B6D, 1, 4, 16'hA5C3, -1, 26, "R8");

    // R9: separate clocks, transmit clock idle
    shared_clk = 0; rx_tied = 0; tx_clk_on = 0; bclk_rx = 0;
    repeat (10) @(negedge clk);
    frame(0, 0, 0, 13'h0000, 0, 0, 16'h6C2E, -1, 20, "R9");
    chk(tx_en_o == 0, "R9", "tx idle without clock", tx_en_o, 0);

    done = 1;
    finish_run();
  end
endmodule